// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor-facing register file of a four-channel DMA controller. It decodes a sixteen-port slice of an 8-bit I/O space and keeps, for each channel, a 16-bit base and current address, a 16-bit base and current count, and a 6-bit mode field. Every port is one byte wide. A 16-bit value therefore moves as two accesses to the same port, and one shared byte-pointer flip-flop chooses the half. The flip-flop starts at the low half and flips after every data-port access. Software clears it before each pair of accesses.

The control ports give the processor these functions:
- a command byte;
- a status byte, which reports latched terminal counts and pending requests;
- software requests;
- per-channel, bulk and global mask control;
- per-channel mode writes;
- a master clear.

The transfer engine beside the block reads the loaded base values, the current values, the modes, the masks and the command byte. It writes new current values back through an update strobe and reports terminal counts and hardware requests.

A port-spacing parameter doubles every offset. With it, a second copy of the block can sit at 0xC0 on even ports only.

Top module: `dmac_port_regs`

## Requirements
- R1: After reset the pointer flip-flop selects the low byte. All mask bits are 1 and the command, request and terminal-count state are 0. Every base and current register and every mode is 0. Reads of unmapped ports return 0x00.
- R2: Channel n (n = 0..3) has its address at offset 2n. A write to that port stores the byte in the half selected by the pointer (low when the pointer is 0), into both the base address and the current address.
- R3: Channel n has its count at offset 2n+1. Writes there follow the same rule and load both the base count and the current count.
- R4: A write of any value to offset 0x0C sets the pointer to the low byte. Every read or write of an offset from 0x00 to 0x07 flips the pointer.
- R5: A read of an address or count port returns the current register: the low byte when the pointer is 0, the high byte when it is 1. An engine update (eng_upd with eng_ch) replaces the current address and count of that channel and leaves the base registers unchanged.
- R6: A write to 0x0A takes the channel from bits 1:0 and uses bit 2 as the new mask bit (1 masks, 0 unmasks). A write to 0x0E clears all four mask bits. A write to 0x0F loads the mask bits from data bits 3:0, with bit i for channel i.
- R7: A write to 0x0B takes the channel from bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode. The other channels keep their modes. As examples, 0x44, 0x48 and 0xC0 store 0x11, 0x12 and 0x30.
- R8: A write to 0x08 loads the command byte. A read of 0x08 returns the status byte: bits 3:0 hold the latched terminal-count flags, and bits 7:4 hold the software request bit OR the eng_dreq input for channels 0 to 3.
- R9: A pulse on eng_tc bit i sets flag i, and the flag stays set until a status read. A status read clears every flag. A pulse in the same cycle as that read still leaves its flag set.
- R10: A write to 0x09 takes the channel from bits 1:0 and uses bit 2 to set (1) or clear (0) that channel's software request, which appears on sw_req.
- R11: A write to 0x0D is a master clear. It resets the pointer to low, clears the command, request and terminal-count state and sets all four mask bits. Base registers, current registers and modes are kept. A read of 0x0D returns 0x00.
- R12: With SPACING = 2 the offset of every port is doubled from BASE. Odd ports and ports outside the window are ignored: they change no state and read 0x00. The default copy (BASE 0x00, SPACING 1) ignores the 0xC0 window.
- R13: When a processor write to an address or count port and an engine update to the same channel fall in the same cycle, the written register takes the processor byte and keeps its other byte. The engine still loads the register that the processor does not touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | I/O port address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe (read side effects occur at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| eng_upd | input | 1 | Engine loads the current address and count of eng_ch |
| eng_ch | input | 2 | Channel for the engine update |
| eng_addr | input | 16 | New current address from the engine |
| eng_cnt | input | 16 | New current count from the engine |
| eng_tc | input | 4 | Terminal-count pulses, one per channel |
| eng_dreq | input | 4 | Hardware request levels, one per channel |
| ch_mode | output | 24 | 6-bit mode per channel; channel i in bits 6i+5:6i |
| ch_mask | output | 4 | Mask bit per channel |
| ch_base_addr | output | 64 | Base addresses; channel i in bits 16i+15:16i |
| ch_base_cnt | output | 64 | Base counts, packed the same way |
| ch_cur_addr | output | 64 | Current addresses, packed the same way |
| ch_cur_cnt | output | 64 | Current counts, packed the same way |
| cmd_q | output | 8 | Command byte |
| sw_req | output | 4 | Software request bits |

## Verification
The byte pointer is driven through whole pairs of accesses, through a single access followed by a clear, and through reads mixed between writes. Together these separate a pointer that flips on every access from one that flips only on writes or that ignores the clear. Random 16-bit values go to random channels and to both register kinds. This catches wrong channel decoding, swapped halves, and a base register that never reaches the current register. Mask and mode bytes are random. Their unused bits are noisy, which shows whether the channel field and the action bit are taken from the right positions. Directed cases cover these points:
- an engine update colliding with a processor write;
- a terminal-count pulse in the same cycle as a status read;
- master clear;
- a doubled-offset copy that must ignore odd ports.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int CW  = 16;
    localparam int MW  = 6;
    localparam int CHW = $clog2(NCH);

    localparam logic [3:0] OFS_CMD    = 4'h8;
    localparam logic [3:0] OFS_REQ    = 4'h9;
    localparam logic [3:0] OFS_MSK1   = 4'hA;
    localparam logic [3:0] OFS_MODE   = 4'hB;
    localparam logic [3:0] OFS_FFCLR  = 4'hC;
    localparam logic [3:0] OFS_MCLR   = 4'hD;
    localparam logic [3:0] OFS_MSKCLR = 4'hE;
    localparam logic [3:0] OFS_MSKALL = 4'hF;

    typedef struct packed {
        logic       hit;
        logic       wr;
        logic       rd;
        logic [3:0] ofs;
    } acc_t;

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic           act;
    } chop_t;

    function automatic chop_t decode_chop(input logic [2:0] b);
        chop_t r;
        r.ch  = b[1:0];
        r.act = b[2];
        return r;
    endfunction

    function automatic logic is_data_port(input logic [3:0] o);
        return !o[3];
    endfunction

endpackage

// File: rtl/dmac_port_dec.sv
module dmac_port_dec
    import dmac_regs_pkg::*;
#(
    parameter logic [7:0] BASE    = 8'h00,
    parameter int         SPACING = 1
) (
    input  logic [7:0] addr,
    input  logic       wr,
    input  logic       rd,
    output acc_t       acc
);
    logic [7:0] diff;
    logic       hit_w;
    logic [3:0] ofs_w;

    assign diff = addr - BASE;

    generate
        if (SPACING == 2) begin : g_even
            assign hit_w = (diff < 8'd32) && !diff[0];
            assign ofs_w = diff[4:1];
        end else begin : g_dense
            assign hit_w = (diff < 8'd16);
            assign ofs_w = diff[3:0];
        end
    endgenerate

    always_comb begin
        acc.hit = hit_w;
        acc.wr  = wr;
        acc.rd  = rd && !wr;
        acc.ofs = ofs_w;
    end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_we,
    input  logic          cnt_we,
    input  logic          hi_sel,
    input  logic [DW-1:0] wdata,
    input  logic          mode_we,
    input  logic [MW-1:0] mode_in,
    input  logic          eng_ld,
    input  logic [CW-1:0] eng_addr,
    input  logic [CW-1:0] eng_cnt,
    output logic [CW-1:0] base_addr,
    output logic [CW-1:0] base_cnt,
    output logic [CW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic [MW-1:0] mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (addr_we) begin
                if (hi_sel) begin
                    base_addr[CW-1:DW] <= wdata;
                    cur_addr[CW-1:DW]  <= wdata;
                end else begin
                    base_addr[DW-1:0]  <= wdata;
                    cur_addr[DW-1:0]   <= wdata;
                end
            end else if (eng_ld) begin
                cur_addr <= eng_addr;
            end

            if (cnt_we) begin
                if (hi_sel) begin
                    base_cnt[CW-1:DW] <= wdata;
                    cur_cnt[CW-1:DW]  <= wdata;
                end else begin
                    base_cnt[DW-1:0]  <= wdata;
                    cur_cnt[DW-1:0]   <= wdata;
                end
            end else if (eng_ld) begin
                cur_cnt <= eng_cnt;
            end

            if (mode_we) mode <= mode_in;
        end
    end
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl
    import dmac_regs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  acc_t           acc,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] eng_tc,
    input  logic [NCH-1:0] eng_dreq,
    output logic [DW-1:0]  cmd_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] tc_q,
    output logic           ptr_hi,
    output logic [DW-1:0]  status
);
    logic  wr_hit, rd_hit, mclr, ffclr, data_acc, stat_rd;
    chop_t op;

    assign wr_hit   = acc.hit && acc.wr;
    assign rd_hit   = acc.hit && acc.rd;
    assign mclr     = wr_hit && (acc.ofs == OFS_MCLR);
    assign ffclr    = wr_hit && (acc.ofs == OFS_FFCLR);
    assign data_acc = (wr_hit || rd_hit) && is_data_port(acc.ofs);
    assign stat_rd  = rd_hit && (acc.ofs == OFS_CMD);
    assign op       = decode_chop(wdata[2:0]);
    assign status   = {req_q | eng_dreq, tc_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            mask_q <= '1;
            req_q  <= '0;
            tc_q   <= '0;
            ptr_hi <= 1'b0;
        end else begin
            if (mclr || ffclr)  ptr_hi <= 1'b0;
            else if (data_acc)  ptr_hi <= !ptr_hi;

            if (mclr)                                cmd_q <= '0;
            else if (wr_hit && acc.ofs == OFS_CMD)   cmd_q <= wdata;

            if (mclr) begin
                mask_q <= '1;
            end else if (wr_hit) begin
                case (acc.ofs)
                    OFS_MSK1:   mask_q[op.ch] <= op.act;
                    OFS_MSKCLR: mask_q        <= '0;
                    OFS_MSKALL: mask_q        <= wdata[NCH-1:0];
                    default:    ;
                endcase
            end

            if (mclr)                                req_q <= '0;
            else if (wr_hit && acc.ofs == OFS_REQ)   req_q[op.ch] <= op.act;

            tc_q <= ((mclr || stat_rd) ? '0 : tc_q) | eng_tc;
        end
    end
endmodule

// File: rtl/dmac_port_regs.sv
module dmac_port_regs
    import dmac_regs_pkg::*;
#(
    parameter logic [7:0] BASE    = 8'h00,
    parameter int         SPACING = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              eng_upd,
    input  logic [CHW-1:0]    eng_ch,
    input  logic [CW-1:0]     eng_addr,
    input  logic [CW-1:0]     eng_cnt,
    input  logic [NCH-1:0]    eng_tc,
    input  logic [NCH-1:0]    eng_dreq,
    output logic [NCH*MW-1:0] ch_mode,
    output logic [NCH-1:0]    ch_mask,
    output logic [NCH*CW-1:0] ch_base_addr,
    output logic [NCH*CW-1:0] ch_base_cnt,
    output logic [NCH*CW-1:0] ch_cur_addr,
    output logic [NCH*CW-1:0] ch_cur_cnt,
    output logic [DW-1:0]     cmd_q,
    output logic [NCH-1:0]    sw_req
);
    acc_t          acc;
    logic          ptr_hi;
    logic [NCH-1:0] tc_flags;
    logic [DW-1:0] status;
    logic [CW-1:0] cur_addr_a [NCH];
    logic [CW-1:0] cur_cnt_a  [NCH];
    logic          wr_hit;

    dmac_port_dec #(.BASE(BASE), .SPACING(SPACING)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .acc(acc)
    );

    dmac_ctl u_ctl (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
        .eng_tc(eng_tc), .eng_dreq(eng_dreq),
        .cmd_q(cmd_q), .mask_q(ch_mask), .req_q(sw_req),
        .tc_q(tc_flags), .ptr_hi(ptr_hi), .status(status)
    );

    assign wr_hit = acc.hit && acc.wr;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic port_sel;
            assign port_sel = is_data_port(acc.ofs) && (acc.ofs[2:1] == CHW'(i));

            dmac_chan u_chan (
                .clk(clk), .rst(rst),
                .addr_we(wr_hit && port_sel && !acc.ofs[0]),
                .cnt_we (wr_hit && port_sel &&  acc.ofs[0]),
                .hi_sel(ptr_hi),
                .wdata(bus_wdata),
                .mode_we(wr_hit && acc.ofs == OFS_MODE && bus_wdata[1:0] == CHW'(i)),
                .mode_in(bus_wdata[DW-1:DW-MW]),
                .eng_ld(eng_upd && eng_ch == CHW'(i)),
                .eng_addr(eng_addr), .eng_cnt(eng_cnt),
                .base_addr(ch_base_addr[i*CW +: CW]),
                .base_cnt (ch_base_cnt [i*CW +: CW]),
                .cur_addr (ch_cur_addr [i*CW +: CW]),
                .cur_cnt  (ch_cur_cnt  [i*CW +: CW]),
                .mode     (ch_mode     [i*MW +: MW])
            );
            assign cur_addr_a[i] = ch_cur_addr[i*CW +: CW];
            assign cur_cnt_a[i]  = ch_cur_cnt [i*CW +: CW];
        end
    endgenerate

    always_comb begin
        logic [CW-1:0] sel;
        sel = acc.ofs[0] ? cur_cnt_a[acc.ofs[2:1]] : cur_addr_a[acc.ofs[2:1]];
        bus_rdata = '0;
        if (acc.hit) begin
            if (is_data_port(acc.ofs))
                bus_rdata = ptr_hi ? sel[CW-1:DW] : sel[DW-1:0];
            else if (acc.ofs == OFS_CMD)
                bus_rdata = status;
        end
    end
endmodule

// File: rtl/dmac_port_regs_chk.sv
module dmac_port_regs_chk
    import dmac_regs_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input acc_t           acc,
    input logic           ptr_hi,
    input logic [NCH-1:0] ch_mask,
    input logic [DW-1:0]  cmd_q,
    input logic [NCH-1:0] sw_req,
    input logic [NCH-1:0] tc_flags,
    input logic [NCH-1:0] eng_tc
);
    // R4
    ffclr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.hit && acc.wr && acc.ofs == OFS_FFCLR) |=> !ptr_hi);

    // R4
    ptr_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.hit && (acc.wr || acc.rd) && !acc.ofs[3]) |=> (ptr_hi != $past(ptr_hi)));

    // R11
    mclr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.hit && acc.wr && acc.ofs == OFS_MCLR) |=>
            (ch_mask == 4'hF && cmd_q == 8'h00 && sw_req == 4'h0 && !ptr_hi));

    // R6
    mskclr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.hit && acc.wr && acc.ofs == OFS_MSKCLR) |=> (ch_mask == 4'h0));

    // R9
    tc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_tc != 4'h0) |=> ((tc_flags & $past(eng_tc)) == $past(eng_tc)));

    // R12
    miss_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc.hit) |=> ($stable(ch_mask) && $stable(cmd_q) && $stable(sw_req)));
endmodule

bind dmac_port_regs dmac_port_regs_chk u_chk (
    .clk(clk), .rst(rst), .acc(acc), .ptr_hi(ptr_hi), .ch_mask(ch_mask),
    .cmd_q(cmd_q), .sw_req(sw_req), .tc_flags(tc_flags), .eng_tc(eng_tc)
);

// File: tb/sim_dmac_port_regs.sv
`timescale 1ns/1ps
module sim_dmac_port_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  rdata0, rdata1;
    logic        eng_upd = 1'b0;
    logic [1:0]  eng_ch = 2'd0;
    logic [15:0] eng_addr = 16'h0, eng_cnt = 16'h0;
    logic [3:0]  eng_tc = 4'h0, eng_dreq = 4'h0;
    logic [23:0] mode0, mode1;
    logic [3:0]  mask0, mask1, req0, req1;
    logic [63:0] ba0, bc0, ca0, cc0, ba1, bc1, ca1, cc1;
    logic [7:0]  cmd0, cmd1;

    int checks = 0, errors = 0;
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [3:0]  m_mask;

    always #2.5 clk = ~clk;

    dmac_port_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .eng_upd(eng_upd), .eng_ch(eng_ch),
        .eng_addr(eng_addr), .eng_cnt(eng_cnt), .eng_tc(eng_tc), .eng_dreq(eng_dreq),
        .ch_mode(mode0), .ch_mask(mask0), .ch_base_addr(ba0), .ch_base_cnt(bc0),
        .ch_cur_addr(ca0), .ch_cur_cnt(cc0), .cmd_q(cmd0), .sw_req(req0)
    );

    dmac_port_regs #(.BASE(8'hC0), .SPACING(2)) u1 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .eng_upd(1'b0), .eng_ch(2'd0),
        .eng_addr(16'h0), .eng_cnt(16'h0), .eng_tc(4'h0), .eng_dreq(4'h0),
        .ch_mode(mode1), .ch_mask(mask1), .ch_base_addr(ba1), .ch_base_cnt(bc1),
        .ch_cur_addr(ca1), .ch_cur_cnt(cc1), .cmd_q(cmd1), .sw_req(req1)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        bus_addr = p; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [7:0] p, output logic [7:0] d0, output logic [7:0] d1);
        @(negedge clk);
        bus_addr = p; bus_rd = 1'b1;
        #1;
        d0 = rdata0; d1 = rdata1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [3:0] mask_after(input logic [3:0] m, input logic [7:0] b);
        logic [3:0] r = m;
        r[b[1:0]] = b[2];
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, b, x;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 mask", mask0, 4'hF);
        chk("R1 cmd", cmd0, 8'h00);
        chk("R1 base", ba0 | bc0 | ca0 | cc0, 64'h0);
        chk("R1 mode", mode0, 24'h0);
        br(8'h10, a, b);
        chk("R1 unmapped read", a, 8'h00);

        // R2 address of channel 1 at offset 2
        bw(8'h0C, 8'h00);
        bw(8'h02, 8'h34); bw(8'h02, 8'h12);
        chk("R2 base addr ch1", ba0[31:16], 16'h1234);
        chk("R2 cur addr ch1", ca0[31:16], 16'h1234);
        // R5 read back low then high
        bw(8'h0C, 8'h00);
        br(8'h02, a, b); br(8'h02, x, b);
        chk("R5 read lo/hi", {x, a}, 16'h1234);

        // R3 count of channel 3 at offset 7
        bw(8'h0C, 8'h5A);
        bw(8'h07, 8'hFF); bw(8'h07, 8'h01);
        chk("R3 base cnt ch3", bc0[63:48], 16'h01FF);
        chk("R3 cur cnt ch3", cc0[63:48], 16'h01FF);

        // R4 clear after a single byte restarts at the low byte
        bw(8'h0C, 8'h00);
        bw(8'h00, 8'hAA);
        bw(8'h0C, 8'hFF);
        bw(8'h00, 8'hBB);
        chk("R4 clear restarts low", ba0[15:0], 16'h00BB);
        // R4 a read flips the pointer: next write goes to high
        bw(8'h0C, 8'h00);
        br(8'h00, a, b);
        bw(8'h00, 8'h77);
        chk("R4 read flips pointer", ba0[15:0], 16'h77BB);

        // R5 engine update touches current only
        @(negedge clk);
        eng_upd = 1'b1; eng_ch = 2'd1; eng_addr = 16'h5566; eng_cnt = 16'h0101;
        @(negedge clk);
        eng_upd = 1'b0;
        chk("R5 cur addr ch1", ca0[31:16], 16'h5566);
        chk("R5 cur cnt ch1", cc0[31:16], 16'h0101);
        chk("R5 base kept", ba0[31:16], 16'h1234);
        bw(8'h0C, 8'h00);
        br(8'h03, a, b); br(8'h03, x, b);
        chk("R5 count read", {x, a}, 16'h0101);

        // R13 collision: processor low byte of ch2 address vs engine update
        bw(8'h0C, 8'h00);
        bw(8'h04, 8'h34); bw(8'h04, 8'h12);
        bw(8'h0C, 8'h00);
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 8'h77; bus_wr = 1'b1;
        eng_upd = 1'b1; eng_ch = 2'd2; eng_addr = 16'h9999; eng_cnt = 16'h2222;
        @(negedge clk);
        bus_wr = 1'b0; eng_upd = 1'b0;
        chk("R13 cpu byte wins", ca0[47:32], 16'h1277);
        chk("R13 engine count", cc0[47:32], 16'h2222);

        // R6 mask operations
        bw(8'h0E, 8'h00);
        chk("R6 clear all", mask0, 4'h0);
        bw(8'h0A, 8'hF6);
        chk("R6 single set ch2", mask0, 4'h4);
        bw(8'h0F, 8'hA9);
        chk("R6 write all", mask0, 4'h9);
        bw(8'h0A, 8'h03);
        chk("R6 single clear ch3", mask0, 4'h1);

        // R7 modes
        bw(8'h0B, 8'h44 | 8'h01);
        bw(8'h0B, 8'h48 | 8'h02);
        bw(8'h0B, 8'hC0 | 8'h03);
        chk("R7 modes", mode0, {6'h30, 6'h12, 6'h11, 6'h00});

        // R8 command
        bw(8'h08, 8'h5A);
        chk("R8 cmd", cmd0, 8'h5A);

        // R10 request set ch2, then R8 status upper nibble with hw request ch3
        bw(8'h09, 8'hF6);
        chk("R10 sw req", req0, 4'h4);
        eng_dreq = 4'h8;
        br(8'h08, a, b);
        chk("R8 status requests", a, 8'hC0);
        eng_dreq = 4'h0;
        bw(8'h09, 8'h02);
        chk("R10 sw req cleared", req0, 4'h0);

        // R9 terminal count latch and clear on read
        @(negedge clk); eng_tc = 4'h2;
        @(negedge clk); eng_tc = 4'h0;
        br(8'h08, a, b);
        chk("R9 tc latched", a, 8'h02);
        br(8'h08, a, b);
        chk("R9 tc cleared by read", a, 8'h00);
        // R9 pulse during the status read survives
        @(negedge clk);
        bus_addr = 8'h08; bus_rd = 1'b1; eng_tc = 4'h1;
        @(negedge clk);
        bus_rd = 1'b0; eng_tc = 4'h0;
        br(8'h08, a, b);
        chk("R9 same-cycle set wins", a, 8'h01);

        // R11 master clear
        bw(8'h09, 8'h05);
        bw(8'h0C, 8'h00);
        bw(8'h00, 8'h11);
        bw(8'h0D, 8'h00);
        chk("R11 mask set", mask0, 4'hF);
        chk("R11 cmd", cmd0, 8'h00);
        chk("R11 req", req0, 4'h0);
        chk("R11 mode kept", mode0, {6'h30, 6'h12, 6'h11, 6'h00});
        chk("R11 base kept", ba0[31:16], 16'h1234);
        br(8'h0D, a, b);
        chk("R11 temp read", a, 8'h00);
        bw(8'h00, 8'h22);
        chk("R11 pointer low", ba0[15:0], 16'h7722);

        // R12 second copy at 0xC0 with doubled offsets
        bw(8'hD0, 8'h3C);
        chk("R12 u1 cmd", cmd1, 8'h3C);
        chk("R12 u0 ignores", cmd0, 8'h00);
        bw(8'hC1, 8'h99);
        chk("R12 odd port ignored", ba1[15:0], 16'h0000);
        bw(8'hD8, 8'h00);
        bw(8'hC4, 8'hCD); bw(8'hC4, 8'hAB);
        chk("R12 u1 ch1 addr", ba1[31:16], 16'hABCD);
        bw(8'hDC, 8'h00);
        chk("R12 u1 clear masks", mask1, 4'h0);
        bw(8'hD8, 8'h00);
        br(8'hC4, a, b); br(8'hC4, a, x);
        chk("R12 u1 read", {x, b}, 16'hABCD);
        br(8'hC5, a, b);
        chk("R12 odd read zero", b, 8'h00);

        // R2 R3 R5 R6 random phase
        for (int c = 0; c < 4; c++) begin
            m_addr[c] = ba0[c*16 +: 16];
            m_cnt[c]  = bc0[c*16 +: 16];
        end
        bw(8'h0F, 8'h05);
        m_mask = 4'h5;
        for (int it = 0; it < 150; it++) begin
            int unsigned ch, kind;
            logic [15:0] v;
            logic [7:0] mb;
            ch = $urandom % 4; kind = $urandom % 2; v = 16'($urandom);
            bw(8'h0C, 8'($urandom));
            bw(8'(ch * 2 + kind), v[7:0]);
            bw(8'(ch * 2 + kind), v[15:8]);
            if (kind == 0) m_addr[ch] = v; else m_cnt[ch] = v;
            chk(kind == 0 ? "R2 random addr" : "R3 random cnt",
                kind == 0 ? ba0[ch*16 +: 16] : bc0[ch*16 +: 16], v);
            bw(8'h0C, 8'h00);
            br(8'(ch * 2 + kind), a, b); br(8'(ch * 2 + kind), x, b);
            chk("R5 random read", {x, a}, kind == 0 ? m_addr[ch] : m_cnt[ch]);
            mb = 8'($urandom);
            bw(8'h0A, mb);
            m_mask = mask_after(m_mask, mb);
            chk("R6 random mask", mask0, m_mask);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule